// File: doc/BRIEF.md
# SMBus Register Slave with Strap-Selected Address

This block is the management-side slave of a two-wire SMBus. It watches the SCL and SDA lines through a short synchronizer and finds START, repeated START and STOP conditions. It recognises its own 7-bit address, acknowledges bytes, and gives the bus master read and write access to a small register bank. SDA is never driven high. The block pulls the line low by raising an output-enable, and the pad does the rest.

The bank holds five byte locations. Four configuration bytes (switch routing, pre-emphasis levels, equalization levels, control) can be read and written. Their contents are also presented on parallel outputs for the datapath they steer. The fifth location is read-only: its low nibble mirrors one signal-present flag per input, and its upper nibble reads as zero. The upper three address bits are fixed. The lower four come from strap pins, so sixteen of these slaves can share one bus. A mode-enable input turns the slave on. Every change of that input, in either direction, returns the bank to its reset contents.

Top module: `smbus_regbank`

## Requirements
- R1: The slave acknowledges (holds SDA low through the ninth clock) an address byte whose upper seven bits equal {3'b101, strap_addr[3:0]}. After any other address it acknowledges nothing and leaves SDA released until the next START.
- R2: A write transfer is: the address with bit 0 = 0, a pointer byte, then data bytes. Each data byte is stored at the pointer, and the pointer then advances by one. The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R3: A read transfer uses the write form to set the pointer, then a repeated START and the address with bit 0 = 1. The slave then sends the byte at the pointer, MSB first. While the master acknowledges with 0, the slave sends the following location. After a 1 (NACK) the slave leaves SDA released.
- R4: A START is a fall of SDA while SCL is high, and a STOP is a rise of SDA while SCL is high. A STOP ends the transfer. A START at any point, including partway through a data byte, abandons the partial byte and begins a new address phase. A partial byte is never stored.
- R5: After reset, locations 0, 1 and 2 hold 0x00 and location 3 holds 0x0F.
- R6: Reading location 4 returns {4'b0000, sig_ok[3:0]}. Bit i is 1 when input i carries a valid signal and 0 when that input is open.
- R7: Writes to location 4 and to any pointer above 4 are acknowledged but change nothing. Reads of pointers above 4 return 0x00.
- R8: Every change of mode_en, in either direction, restores the reset contents of R5. While mode_en is 0, the slave acknowledges no address and never drives SDA.
- R9: sda_oe (1 = pull SDA low) changes only while SCL is low.
- R10: route_cfg, emph_cfg, eqlz_cfg and ctrl_cfg always equal locations 0 to 3. They change only through a completed bus write byte or a mode_en change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Enables the slave; any change clears the bank |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired bus, including own drive) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_addr | input | 4 | Low four bits of the slave address |
| sig_ok | input | 4 | Per-input signal-present flags |
| route_cfg | output | 8 | Location 0 contents |
| emph_cfg | output | 8 | Location 1 contents |
| eqlz_cfg | output | 8 | Location 2 contents |
| ctrl_cfg | output | 8 | Location 3 contents |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a four-bit strap and prefix 101. It drives SCL with a half period of ten system clocks, which is only modestly above the 16x minimum. That ratio checks that the three-clock lag of the synchronizer still places every SDA change well inside the SCL-low window. The four-bit strap lets the bench move the slave to a second address and check that only the new pattern is answered. The 8-bit pointer lets a burst starting at 0xFF show the wrap back to location 0.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int BYTE_W   = 8;
    localparam int CFG_REGS = 4;
    localparam int CTRL_IDX = 3;
    localparam logic [BYTE_W-1:0] CTRL_RST = 8'h0F;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_WBYTE,
        LK_WACK,
        LK_RBYTE,
        LK_RACK,
        LK_SKIP
    } link_st_e;

    typedef struct packed {
        link_st_e   st;
        byte_t      shreg;
        logic [3:0] bitcnt;
        byte_t      ptr;
        logic       rw;
        logic       need_ptr;
        logic       mack;
        logic       oe;
        logic       wr_en;
        byte_t      wr_addr;
        byte_t      wr_data;
    } link_t;

    localparam link_t LINK_IDLE = '{
        st:       LK_IDLE,
        shreg:    '0,
        bitcnt:   '0,
        ptr:      '0,
        rw:       1'b0,
        need_ptr: 1'b1,
        mack:     1'b0,
        oe:       1'b0,
        wr_en:    1'b0,
        wr_addr:  '0,
        wr_data:  '0
    };

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_c;
        logic [STAGES-1:0] sda_c;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;
    logic [STAGES-1:0] scl_shift;
    logic [STAGES-1:0] sda_shift;
    logic              scl_s;

    generate
        if (STAGES == 1) begin : g_single
            assign scl_shift = scl_raw;
            assign sda_shift = sda_raw;
        end else begin : g_chain
            assign scl_shift = {s_q.scl_c[STAGES-2:0], scl_raw};
            assign sda_shift = {s_q.sda_c[STAGES-2:0], sda_raw};
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.scl_c = scl_shift;
        s_d.sda_c = sda_shift;
        s_d.scl_p = s_q.scl_c[STAGES-1];
        s_d.sda_p = s_q.sda_c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_s     = s_q.scl_c[STAGES-1];
    assign sda_s     = s_q.sda_c[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_det = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smbreg_pkg::*;
#(
    parameter int                 STRAP_W    = 4,
    parameter logic [6-STRAP_W:0] DEV_PREFIX = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               enable,
    input  logic [STRAP_W-1:0] strap,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_s,
    input  logic               start_det,
    input  logic               stop_det,
    input  byte_t              rd_data,
    output logic               sda_oe,
    output byte_t              rd_addr,
    output logic               wr_en,
    output byte_t              wr_addr,
    output byte_t              wr_data
);

    localparam logic [3:0] LAST_BIT = 4'd8;

    link_t q, d;
    logic  addr_hit;

    assign addr_hit = enable && (q.shreg[7:1] == {DEV_PREFIX, strap});

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (clear) begin
            d = LINK_IDLE;
        end else if (start_det) begin
            d.st       = LK_ADDR;
            d.bitcnt   = '0;
            d.oe       = 1'b0;
            d.need_ptr = 1'b1;
        end else if (stop_det) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                LK_ADDR: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == LAST_BIT) begin
                        if (addr_hit) begin
                            d.oe = 1'b1;
                            d.rw = q.shreg[0];
                            d.st = LK_AACK;
                        end else begin
                            d.st = LK_SKIP;
                        end
                    end
                end
                LK_AACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.shreg = rd_data;
                            d.oe    = ~rd_data[7];
                            d.st    = LK_RBYTE;
                        end else begin
                            d.oe = 1'b0;
                            d.st = LK_WBYTE;
                        end
                    end
                end
                LK_WBYTE: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == LAST_BIT) begin
                        d.oe = 1'b1;
                        d.st = LK_WACK;
                        if (q.need_ptr) begin
                            d.ptr      = q.shreg;
                            d.need_ptr = 1'b0;
                        end else begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.ptr;
                            d.wr_data = q.shreg;
                            d.ptr     = q.ptr + 8'd1;
                        end
                    end
                end
                LK_WACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        d.st     = LK_WBYTE;
                    end
                end
                LK_RBYTE: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = LK_RACK;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                LK_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        if (!sda_s) begin
                            d.ptr = q.ptr + 8'd1;
                        end
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.shreg  = rd_data;
                            d.oe     = ~rd_data[7];
                            d.bitcnt = '0;
                            d.st     = LK_RBYTE;
                        end else begin
                            d.st = LK_SKIP;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= LINK_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign rd_addr = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smbreg_pkg::*;
#(
    parameter int NCFG  = CFG_REGS,
    parameter int LOS_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  byte_t                        wr_addr,
    input  byte_t                        wr_data,
    input  byte_t                        rd_addr,
    input  logic [LOS_W-1:0]             sig_ok,
    output byte_t                        rd_data,
    output logic [NCFG-1:0][BYTE_W-1:0]  cfg_o
);

    localparam byte_t STATUS_ADDR = BYTE_W'(NCFG);

    logic [NCFG-1:0][BYTE_W-1:0] cfg_d, cfg_q;

    function automatic byte_t rst_val(input int idx);
        return (idx == CTRL_IDX) ? CTRL_RST : '0;
    endfunction

    always_comb begin
        for (int i = 0; i < NCFG; i++) begin
            if (clear) begin
                cfg_d[i] = rst_val(i);
            end else if (wr_en && wr_addr == BYTE_W'(i)) begin
                cfg_d[i] = wr_data;
            end else begin
                cfg_d[i] = cfg_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCFG; i++) begin
                cfg_q[i] <= rst_val(i);
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCFG; i++) begin
            if (rd_addr == BYTE_W'(i)) begin
                rd_data = cfg_q[i];
            end
        end
        if (rd_addr == STATUS_ADDR) begin
            rd_data = {{(BYTE_W-LOS_W){1'b0}}, sig_ok};
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/smbus_regbank.sv
module smbus_regbank
    import smbreg_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 STRAP_W     = 4,
    parameter logic [6-STRAP_W:0] DEV_PREFIX  = 3'b101,
    parameter int                 LOS_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [LOS_W-1:0]   sig_ok,
    output logic [7:0]         route_cfg,
    output logic [7:0]         emph_cfg,
    output logic [7:0]         eqlz_cfg,
    output logic [7:0]         ctrl_cfg
);

    logic  mode_d, mode_q;
    logic  clear;
    logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
    byte_t rd_addr, rd_data, wr_addr, wr_data;
    logic  wr_en;
    logic [CFG_REGS-1:0][BYTE_W-1:0] cfg;

    always_comb begin
        mode_d = mode_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign clear = mode_en ^ mode_q;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_link #(
        .STRAP_W    (STRAP_W),
        .DEV_PREFIX (DEV_PREFIX)
    ) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .enable    (mode_en),
        .strap     (strap_addr),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    smb_regfile #(
        .NCFG  (CFG_REGS),
        .LOS_W (LOS_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .sig_ok  (sig_ok),
        .rd_data (rd_data),
        .cfg_o   (cfg)
    );

    assign route_cfg = cfg[0];
    assign emph_cfg  = cfg[1];
    assign eqlz_cfg  = cfg[2];
    assign ctrl_cfg  = cfg[3];

endmodule

// File: rtl/smbus_regbank_chk.sv
module smbus_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_en,
    input logic       scl_in,
    input logic       sda_oe,
    input logic [7:0] route_cfg,
    input logic [7:0] emph_cfg,
    input logic [7:0] eqlz_cfg,
    input logic [7:0] ctrl_cfg
);

    assert_toggle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en != $past(mode_en)) |=>
            (route_cfg == 8'h00 && emph_cfg == 8'h00 &&
             eqlz_cfg == 8'h00 && ctrl_cfg == 8'h0F))
        else $error("bank not restored after mode change");

    assert_silent_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !sda_oe)
        else $error("SDA driven while slave disabled");

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in)
        else $error("SDA pull started while SCL high");

    assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_en && !$past(mode_en) && !$past(mode_en, 2)) |->
            $stable({route_cfg, emph_cfg, eqlz_cfg, ctrl_cfg}))
        else $error("configuration changed while slave disabled");

endmodule

bind smbus_regbank smbus_regbank_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .route_cfg (route_cfg),
    .emph_cfg  (emph_cfg),
    .eqlz_cfg  (eqlz_cfg),
    .ctrl_cfg  (ctrl_cfg)
);

// File: tb/smbus_regbank_tb_top.sv
module smbus_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       mode_en = 1'b0;
    logic       m_scl   = 1'b1;
    logic       m_sda   = 1'b1;
    logic [3:0] strap   = 4'b0011;
    logic [3:0] sig_ok  = 4'b0000;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] route_cfg, emph_cfg, eqlz_cfg, ctrl_cfg;

    int   n_chk   = 0;
    int   n_fail  = 0;
    int   oe_viol = 0;
    bit   cmp_en  = 1'b0;
    bit   done    = 1'b0;
    logic oe_prev = 1'b0;
    logic [7:0] m_reg [4];

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_regbank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .scl_in     (m_scl),
        .sda_in     (sda_bus),
        .sda_oe     (sda_oe),
        .strap_addr (strap),
        .sig_ok     (sig_ok),
        .route_cfg  (route_cfg),
        .emph_cfg   (emph_cfg),
        .eqlz_cfg   (eqlz_cfg),
        .ctrl_cfg   (ctrl_cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_reg[0] = 8'h00;
        m_reg[1] = 8'h00;
        m_reg[2] = 8'h00;
        m_reg[3] = 8'h0F;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] p);
        if (p < 8'd4) return m_reg[p[1:0]];
        if (p == 8'd4) return {4'b0000, sig_ok};
        return 8'h00;
    endfunction

    function automatic logic [6:0] dev_of(input logic [3:0] s);
        return {3'b101, s};
    endfunction

    // Reference registers compared on every clock while the bus is quiet (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== oe_prev && m_scl) oe_viol++;
            oe_prev = sda_oe;
        end
        if (cmp_en) begin
            n_chk++;
            if ({route_cfg, emph_cfg, eqlz_cfg, ctrl_cfg, sda_oe} !==
                {m_reg[0], m_reg[1], m_reg[2], m_reg[3], 1'b0}) begin
                n_fail++;
                $display("FAIL R10 actual=%h_%h_%h_%h oe=%b expected=%h_%h_%h_%h oe=0",
                         route_cfg, emph_cfg, eqlz_cfg, ctrl_cfg, sda_oe,
                         m_reg[0], m_reg[1], m_reg[2], m_reg[3]);
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(HALF);
            m_scl = 1'b1; tick(HALF);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF/2);
        ack = ~sda_bus;
        tick(HALF - HALF/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(HALF);
            m_scl = 1'b1; tick(HALF/2);
            b[i] = sda_bus;
            tick(HALF - HALF/2);
            m_scl = 1'b0;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0;
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] p, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input bit exp_ack, input string tag);
        bit         ack;
        logic [7:0] dv;
        cmp_en = 1'b0;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        check({tag, " address ack"}, 32'(ack), 32'(exp_ack));
        send_byte(p, ack);
        check({tag, " pointer ack"}, 32'(ack), 32'(exp_ack));
        for (int i = 0; i < n; i++) begin
            dv = (i == 0) ? d0 : ((i == 1) ? d1 : d2);
            send_byte(dv, ack);
            check({tag, " data ack"}, 32'(ack), 32'(exp_ack));
            if (exp_ack && p < 8'd4) m_reg[p[1:0]] = dv;
            p = p + 8'd1;
        end
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
    endtask

    task automatic rd_txn(input logic [6:0] dev, input logic [7:0] p, input int n);
        bit         ack;
        logic [7:0] b;
        string      tag;
        cmp_en = 1'b0;
        bus_start();
        send_byte({dev, 1'b0}, ack);
        check("R3 read address-write ack", 32'(ack), 32'd1);
        send_byte(p, ack);
        check("R3 read pointer ack", 32'(ack), 32'd1);
        bus_start();
        send_byte({dev, 1'b1}, ack);
        check("R3 read address-read ack", 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            tag = (p < 8'd4) ? "R3 read data" : ((p == 8'd4) ? "R6 status read" : "R7 read beyond map");
            check(tag, 32'(b), 32'(model_rd(p)));
            p = p + 8'd1;
        end
        tick(4);
        check("R3 released after NACK", 32'(sda_oe), 32'd0);
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
    endtask

    initial begin
        bit ack;
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R5 reset contents
        check("R5 route reset", 32'(route_cfg), 32'h00);
        check("R5 emph reset", 32'(emph_cfg), 32'h00);
        check("R5 eqlz reset", 32'(eqlz_cfg), 32'h00);
        check("R5 ctrl reset", 32'(ctrl_cfg), 32'h0F);
        check("R9 idle release", 32'(sda_oe), 32'd0);
        mode_en = 1'b1;
        tick(4);
        cmp_en = 1'b1;

        // R2 burst with auto increment, then control byte
        wr_txn(dev_of(strap), 8'h00, 3, 8'hA5, 8'h3C, 8'h96, 1'b1, "R2 burst");
        wr_txn(dev_of(strap), 8'h03, 1, 8'hC7, 8'h00, 8'h00, 1'b1, "R2 single");
        // R3 R6 R7 read across the whole map and beyond
        sig_ok = 4'b1010;
        rd_txn(dev_of(strap), 8'h00, 6);

        // R1 foreign address is ignored
        wr_txn(7'b1010000, 8'h00, 2, 8'hFF, 8'hEE, 8'h00, 1'b0, "R1 foreign");
        wr_txn(7'b0010011, 8'h01, 1, 8'h44, 8'h00, 8'h00, 1'b0, "R1 prefix mismatch");

        // R7 writes to status and beyond are acked and dropped
        wr_txn(dev_of(strap), 8'h04, 2, 8'h77, 8'h55, 8'h00, 1'b1, "R7 ignored writes");
        sig_ok = 4'b0101;
        rd_txn(dev_of(strap), 8'h04, 2);

        // R2 pointer wrap from 0xFF to 0x00
        wr_txn(dev_of(strap), 8'hFF, 2, 8'h11, 8'h22, 8'h00, 1'b1, "R2 wrap");
        rd_txn(dev_of(strap), 8'h00, 1);

        // R1 new strap value moves the slave
        strap = 4'b1100;
        tick(4);
        wr_txn(7'b1010011, 8'h02, 1, 8'h99, 8'h00, 8'h00, 1'b0, "R1 old strap");
        wr_txn(dev_of(strap), 8'h01, 1, 8'h6B, 8'h00, 8'h00, 1'b1, "R1 new strap");
        rd_txn(dev_of(strap), 8'h01, 2);

        // R4 START partway through a data byte abandons it
        cmp_en = 1'b0;
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        check("R4 address ack", 32'(ack), 32'd1);
        send_byte(8'h01, ack);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        check("R4 restart address ack", 32'(ack), 32'd1);
        send_byte(8'h02, ack);
        send_byte(8'h5A, ack);
        check("R4 restart data ack", 32'(ack), 32'd1);
        m_reg[2] = 8'h5A;
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
        // R4 STOP partway through a data byte stores nothing
        cmp_en = 1'b0;
        bus_start();
        send_byte({dev_of(strap), 1'b0}, ack);
        send_byte(8'h00, ack);
        send_bits(8'h0F, 4);
        bus_stop();
        tick(4);
        cmp_en = 1'b1;
        rd_txn(dev_of(strap), 8'h00, 3);

        // R8 mode change restores defaults and silences the slave
        cmp_en = 1'b0;
        mode_en = 1'b0;
        model_reset();
        tick(3);
        cmp_en = 1'b1;
        check("R8 route cleared", 32'(route_cfg), 32'h00);
        check("R8 ctrl restored", 32'(ctrl_cfg), 32'h0F);
        wr_txn(dev_of(strap), 8'h00, 1, 8'h12, 8'h00, 8'h00, 1'b0, "R8 disabled");
        cmp_en = 1'b0;
        mode_en = 1'b1;
        tick(3);
        cmp_en = 1'b1;
        wr_txn(dev_of(strap), 8'h02, 1, 8'h3E, 8'h00, 8'h00, 1'b1, "R8 re-enabled");
        check("R10 eqlz output", 32'(eqlz_cfg), 32'h3E);

        check("R9 SDA steady while SCL high", 32'(oe_viol), 32'd0);
        tick(10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule